// File: doc/BRIEF.md
# Embedded Operation Status Bit Generator

This block forms the status byte and the ready/busy level that a host sees when it reads a flash device while an internal program or erase is running. A controller elsewhere owns the operation sequencing and the array; it tells this block which operation is active, which bit 7 value is being written, the address under program, which sectors are marked for erase, and the sector that the current read address decodes to. On every host read, the block decides whether the data bus carries status or array data, and it advances the two toggle bits.

The polling bit reflects the data being written or the erase state. The general toggle bit advances on each read while work is in progress. The sector toggle bit advances only on reads from sectors that are erasing or suspended from erase. A sticky bit records a time-limit overrun, and a fourth bit reports that the erase load window has closed. Both toggle bits advance once per rising edge of the read strobe, so a strobe held high for several clocks counts as one read.

Top module: `pe_status_gen`

## Requirements
- R1: In program (op_state 1) st_q7 is the inverse of prog_d7 and st_sel is 1; in erase (op_state 2) st_q7 is 0 and st_sel is 1 for reads from any sector.
- R2: While program, erase or suspended program is active, st_q6 flips once per rising edge of rd_stb, and holding rd_stb high for several clocks gives only one flip.
- R3: In erase, st_q2 flips on a read whose rd_sector has its bit set in susp_map, and keeps its value on reads from a sector whose bit is clear.
- R4: In erase-suspend (op_state 3), a read from a sector marked in susp_map gives st_sel 1, st_q7 1, an unchanged st_q6 and a flipped st_q2; a read from an unmarked sector gives st_sel 0.
- R5: In program-within-suspend (op_state 4), a read with rd_addr equal to prog_addr gives st_sel 1, st_q2 1 and st_q7 the inverse of prog_d7; a read from another address in a marked sector gives st_sel 1, st_q7 1, and flips st_q2.
- R6: st_q5 becomes 1 on the clock after tmo is seen during an active operation, stays 1 until rst_cmd is seen, and a tmo while idle leaves it 0.
- R7: st_q3 is 1 only in erase with win_closed high; it is 0 in erase before the window closes and in every other operation state.
- R8: ready is 0 for op_state 1, 2 and 4, and 1 for op_state 0 and 3 (codes 5 to 7 act as idle).
- R9: When op_state is idle, st_sel is 0 and, one clock later, st_q6 and st_q2 are 0, so the next operation starts its toggles from 0.
- R10: After reset all status outputs and st_sel are 0 and ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_state | input | 3 | Operation: 0 idle, 1 program, 2 erase, 3 erase-suspend, 4 program in suspend |
| prog_d7 | input | 1 | Bit 7 of the data being programmed |
| prog_addr | input | AW | Address under program |
| rd_addr | input | AW | Host read address |
| susp_map | input | NSEC | One bit per sector marked for erase or suspended |
| rd_sector | input | SW | Sector decode of rd_addr |
| rd_stb | input | 1 | Host read strobe |
| tmo | input | 1 | Operation time limit exceeded |
| win_closed | input | 1 | Sector erase load window closed |
| rst_cmd | input | 1 | Reset command seen, clears the sticky bit |
| st_q7 | output | 1 | Data polling bit |
| st_q6 | output | 1 | General toggle bit |
| st_q5 | output | 1 | Sticky time-limit bit |
| st_q3 | output | 1 | Erase window closed bit |
| st_q2 | output | 1 | Sector toggle bit |
| st_sel | output | 1 | 1 selects status, 0 selects array data |
| ready | output | 1 | 1 ready, 0 busy |

## Verification
The bench builds the block with its defaults, an 8-bit address and eight sectors, so the 3-bit sector decode reaches a marked sector and an unmarked one in every mode. It walks one continuous erase, suspend and suspended-program sequence so the toggle state carried across mode changes is compared against a count of reads kept in the bench. Held strobes, timeouts while idle and a closing load window cover the edge-only and mode-gated corners.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_PROG  = 3'd1,
    OP_ERASE = 3'd2,
    OP_ESUSP = 3'd3,
    OP_SPROG = 3'd4
  } op_e;

  // Work in progress: the array is busy and ready is low.
  function automatic logic fn_busy(input logic [2:0] op);
    return (op == OP_PROG) || (op == OP_ERASE) || (op == OP_SPROG);
  endfunction

  // Any defined non-idle state: toggle state is retained.
  function automatic logic fn_active(input logic [2:0] op);
    return fn_busy(op) || (op == OP_ESUSP);
  endfunction
endpackage

// File: rtl/pes_edge.sv
module pes_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic din_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_q <= 1'b0;
    else        din_q <= din;
  end
  assign rise = din & ~din_q;
endmodule

// File: rtl/pes_toggle.sv
module pes_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (adv) q <= ~q;
  end
endmodule

// File: rtl/pes_sticky.sv
module pes_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (set) q <= 1'b1;
  end
endmodule

// File: rtl/pes_decode.sv
module pes_decode
  import pe_status_pkg::*;
#(
  parameter int AW   = 8,
  parameter int NSEC = 8,
  localparam int SW  = (NSEC > 1) ? $clog2(NSEC) : 1
) (
  input  logic [2:0]      op_state,
  input  logic            prog_d7,
  input  logic [AW-1:0]   prog_addr,
  input  logic [AW-1:0]   rd_addr,
  input  logic [NSEC-1:0] susp_map,
  input  logic [SW-1:0]   rd_sector,
  input  logic            win_closed,
  output logic            sel,
  output logic            q7,
  output logic            q3,
  output logic            q2_force,
  output logic            en6,
  output logic            en2
);
  logic sec_hit;
  logic addr_hit;

  always_comb begin
    sec_hit = 1'b0;
    for (int i = 0; i < NSEC; i++)
      if (rd_sector == SW'(i)) sec_hit = susp_map[i];
  end

  assign addr_hit = (rd_addr == prog_addr);

  always_comb begin
    sel      = 1'b0;
    q7       = 1'b0;
    q3       = 1'b0;
    q2_force = 1'b0;
    en6      = fn_busy(op_state);
    en2      = 1'b0;
    case (op_e'(op_state))
      OP_PROG: begin
        sel = 1'b1;
        q7  = ~prog_d7;
      end
      OP_ERASE: begin
        sel = 1'b1;
        q3  = win_closed;
        en2 = sec_hit;
      end
      OP_ESUSP: begin
        sel = sec_hit;
        q7  = sec_hit;
        en2 = sec_hit;
      end
      OP_SPROG: begin
        sel      = addr_hit | sec_hit;
        q7       = addr_hit ? ~prog_d7 : sec_hit;
        q2_force = addr_hit;
        en2      = sec_hit & ~addr_hit;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pe_status_gen.sv
module pe_status_gen
  import pe_status_pkg::*;
#(
  parameter int AW   = 8,
  parameter int NSEC = 8,
  localparam int SW  = (NSEC > 1) ? $clog2(NSEC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      op_state,
  input  logic            prog_d7,
  input  logic [AW-1:0]   prog_addr,
  input  logic [AW-1:0]   rd_addr,
  input  logic [NSEC-1:0] susp_map,
  input  logic [SW-1:0]   rd_sector,
  input  logic            rd_stb,
  input  logic            tmo,
  input  logic            win_closed,
  input  logic            rst_cmd,
  output logic            st_q7,
  output logic            st_q6,
  output logic            st_q5,
  output logic            st_q3,
  output logic            st_q2,
  output logic            st_sel,
  output logic            ready
);
  localparam int NTOG = 2;

  logic            rd_rise;
  logic            q2_force;
  logic            en6, en2;
  logic            tog_clr;
  logic [NTOG-1:0] tog_en;
  logic [NTOG-1:0] tog_q;

  pes_edge u_edge (
    .clk(clk), .rst_n(rst_n), .din(rd_stb), .rise(rd_rise)
  );

  pes_decode #(.AW(AW), .NSEC(NSEC)) u_dec (
    .op_state(op_state), .prog_d7(prog_d7), .prog_addr(prog_addr),
    .rd_addr(rd_addr), .susp_map(susp_map), .rd_sector(rd_sector),
    .win_closed(win_closed), .sel(st_sel), .q7(st_q7), .q3(st_q3),
    .q2_force(q2_force), .en6(en6), .en2(en2)
  );

  assign tog_clr = ~fn_active(op_state);
  assign tog_en  = {en2, en6};

  // index 0: general toggle, index 1: sector toggle
  for (genvar g = 0; g < NTOG; g++) begin : g_tog
    pes_toggle u_tog (
      .clk(clk), .rst_n(rst_n), .clr(tog_clr),
      .adv(rd_rise & tog_en[g]), .q(tog_q[g])
    );
  end

  pes_sticky u_tmo (
    .clk(clk), .rst_n(rst_n), .clr(rst_cmd),
    .set(tmo & fn_busy(op_state)), .q(st_q5)
  );

  assign st_q6 = tog_q[0];
  assign st_q2 = tog_q[1] | q2_force;
  assign ready = ~fn_busy(op_state);
endmodule

// File: rtl/pes_status_chk.sv
module pes_status_chk
  import pe_status_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    op_state,
  input logic          prog_d7,
  input logic [AW-1:0] prog_addr,
  input logic [AW-1:0] rd_addr,
  input logic          rst_cmd,
  input logic          rd_rise,
  input logic          tog6,
  input logic          st_q7,
  input logic          st_q2,
  input logic          st_q5,
  input logic          st_sel,
  input logic          ready
);
  a_r1_prog_q7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == OP_PROG) |-> (st_q7 == !prog_d7) && st_sel);

  a_r2_q6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_rise && fn_active(op_state)) |=> $stable(tog6));

  a_r4_susp_q6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == OP_ESUSP) |=> $stable(tog6));

  a_r5_sprog_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == OP_SPROG && rd_addr == prog_addr) |-> st_q2 && st_sel);

  a_r6_q5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q5 && !rst_cmd) |=> st_q5);

  a_r6_q5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> !st_q5);

  a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == OP_PROG || op_state == OP_ERASE || op_state == OP_SPROG) |-> !ready);
endmodule

bind pe_status_gen pes_status_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_state(op_state), .prog_d7(prog_d7),
  .prog_addr(prog_addr), .rd_addr(rd_addr), .rst_cmd(rst_cmd),
  .rd_rise(rd_rise), .tog6(tog_q[0]), .st_q7(st_q7), .st_q2(st_q2),
  .st_q5(st_q5), .st_sel(st_sel), .ready(ready)
);

// File: tb/pe_status_gen_tb.sv
module pe_status_gen_tb;
  localparam int AW = 8;
  localparam int NSEC = 8;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] op_state = 3'd0;
  logic prog_d7 = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [NSEC-1:0] susp_map = '0;
  logic [SW-1:0] rd_sector = '0;
  logic rd_stb = 1'b0, tmo = 1'b0, win_closed = 1'b0, rst_cmd = 1'b0;
  logic st_q7, st_q6, st_q5, st_q3, st_q2, st_sel, ready;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;
  logic r7, r6, r2, rsel;

  always #2 clk = ~clk;

  pe_status_gen #(.AW(AW), .NSEC(NSEC)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_state(op_state), .prog_d7(prog_d7),
    .prog_addr(prog_addr), .rd_addr(rd_addr), .susp_map(susp_map),
    .rd_sector(rd_sector), .rd_stb(rd_stb), .tmo(tmo),
    .win_closed(win_closed), .rst_cmd(rst_cmd), .st_q7(st_q7),
    .st_q6(st_q6), .st_q5(st_q5), .st_q3(st_q3), .st_q2(st_q2),
    .st_sel(st_sel), .ready(ready)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [SW-1:0] s, input int hold);
    rd_addr = a; rd_sector = s; rd_stb = 1'b1;
    repeat (hold) @(negedge clk);
    r7 = st_q7; r6 = st_q6; r2 = st_q2; rsel = st_sel;
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 q7", st_q7, 0); chk("R10 q6", st_q6, 0); chk("R10 q5", st_q5, 0);
    chk("R10 q3", st_q3, 0); chk("R10 q2", st_q2, 0); chk("R10 sel", st_sel, 0);
    chk("R10 ready", ready, 1);
  endtask

  task automatic t_program();
    op_state = 3'd1; prog_d7 = 1'b1; win_closed = 1'b1;
    @(negedge clk);
    chk("R8 prog busy", ready, 0);
    chk("R7 q3 not in program", st_q3, 0);
    do_read(8'h10, 3'd0, 1);
    chk("R1 prog q7", r7, 0); chk("R1 prog sel", rsel, 1); chk("R2 q6 first", r6, 1);
    do_read(8'h10, 3'd0, 1);
    chk("R2 q6 second", r6, 0);
    do_read(8'h10, 3'd0, 4);
    chk("R2 held strobe one flip", r6, 1);
    prog_d7 = 1'b0; @(negedge clk);
    chk("R1 prog q7 inv", st_q7, 1);
    win_closed = 1'b0;
  endtask

  task automatic t_idle();
    op_state = 3'd0;
    @(negedge clk);
    chk("R9 idle sel", st_sel, 0); chk("R9 idle q6", st_q6, 0);
    chk("R9 idle q2", st_q2, 0); chk("R8 idle ready", ready, 1);
  endtask

  task automatic t_erase();
    op_state = 3'd2; susp_map = 8'b0000_0100; win_closed = 1'b0;
    @(negedge clk);
    chk("R7 q3 before window", st_q3, 0);
    chk("R8 erase busy", ready, 0);
    win_closed = 1'b1; @(negedge clk);
    chk("R7 q3 window closed", st_q3, 1);
    do_read(8'h20, 3'd2, 1);
    chk("R1 erase q7", r7, 0); chk("R2 erase q6", r6, 1); chk("R3 q2 erasing sector", r2, 1);
    do_read(8'h50, 3'd5, 1);
    chk("R1 erase sel other", rsel, 1); chk("R2 q6 other", r6, 0);
    chk("R3 q2 held other sector", r2, 1);
    do_read(8'h21, 3'd2, 1);
    chk("R3 q2 second flip", r2, 0); chk("R2 q6 third", r6, 1);
    win_closed = 1'b0;
  endtask

  task automatic t_suspend();
    op_state = 3'd3;
    @(negedge clk);
    chk("R8 suspend ready", ready, 1);
    chk("R7 q3 in suspend", st_q3, 0);
    do_read(8'h20, 3'd2, 1);
    chk("R4 susp sel", rsel, 1); chk("R4 susp q7", r7, 1);
    chk("R4 susp q6 held", r6, 1); chk("R4 susp q2 flip", r2, 1);
    do_read(8'h22, 3'd2, 1);
    chk("R4 susp q2 flip2", r2, 0); chk("R4 susp q6 held2", r6, 1);
    do_read(8'h50, 3'd5, 1);
    chk("R4 other sector array", rsel, 0);
  endtask

  task automatic t_sprog();
    op_state = 3'd4; prog_addr = 8'h33; prog_d7 = 1'b1;
    @(negedge clk);
    chk("R8 sprog busy", ready, 0);
    do_read(8'h33, 3'd5, 1);
    chk("R5 hit sel", rsel, 1); chk("R5 hit q2", r2, 1); chk("R5 hit q7", r7, 0);
    chk("R2 sprog q6", r6, 0);
    do_read(8'h40, 3'd2, 1);
    chk("R5 susp sector sel", rsel, 1); chk("R5 susp sector q7", r7, 1);
    chk("R5 susp sector q2 flip", r2, 1); chk("R2 sprog q6 again", r6, 1);
  endtask

  task automatic t_timeout();
    op_state = 3'd0; tmo = 1'b1; @(negedge clk); tmo = 1'b0; @(negedge clk);
    chk("R6 tmo idle ignored", st_q5, 0);
    op_state = 3'd1; tmo = 1'b1; @(negedge clk); tmo = 1'b0;
    chk("R6 q5 set", st_q5, 1);
    repeat (3) @(negedge clk);
    chk("R6 q5 sticky", st_q5, 1);
    op_state = 3'd0; @(negedge clk);
    chk("R6 q5 kept idle", st_q5, 1);
    rst_cmd = 1'b1; @(negedge clk); rst_cmd = 1'b0;
    chk("R6 q5 cleared", st_q5, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_program();
    t_idle();
    t_erase();
    t_suspend();
    t_sprog();
    t_idle();
    t_timeout();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule